// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read data path of a byte-wide non-volatile memory model. While the programming timer reports an internal write cycle in progress, the block changes the data that a host reads. Bit 7 carries the complement of bit 7 of the last byte written, and bit 6 flips on every new read access. A host can therefore detect the end of a write in either of two ways. It can poll until bit 7 matches the value it wrote, or it can read repeatedly until bit 6 stops changing. Once the timer reports idle, the block passes array data through unchanged.

A read access needs chip enable and output enable low (both are active-low inputs) and write enable high. A new access starts when that condition rises, so the host can frame separate reads by pulsing output enable, chip enable, or both. The block reacts only to the busy flag. A write that the protection logic rejects, but that still starts the timer, produces the same polling behaviour for the whole busy period. Both outputs are registered and follow the inputs of the previous clock.

Top module: `wr_status_reporter`

## Requirements
- R1: `rd_oe` is 1 in the cycle after a cycle in which `ce_n`=0, `oe_n`=0 and `we_n`=1, and 0 otherwise. Whenever `rd_oe` is 0, `rd_data` is all zeros.
- R2: If `busy` was 0 in the sampled cycle, `rd_data` equals the sampled `array_data` on all 8 bits.
- R3: If `busy` was 1 in the sampled cycle, `rd_data[7]` is the inverse of the sampled `last_wr_bit`.
- R4: If `busy` was 1, `rd_data[6]` shows the toggle state. The toggle state inverts once at the first cycle of each read access made while busy, and stays constant for the rest of that access.
- R5: If `busy` was 1, `rd_data[5:0]` equal the sampled `array_data[5:0]`.
- R6: A new access starts only when the read condition goes from false to true. This happens when `oe_n` alone, `ce_n` alone, or both are raised and then lowered. Lowering `we_n` also ends the read condition.
- R7: The toggle state resets to 0 and never changes while `busy` is 0. It carries its value from one write cycle to the next and is not reinitialised when a write begins.
- R8: During reset, `rd_oe` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | Internal write cycle in progress (from the programming timer) |
| last_wr_bit | input | 1 | Bit 7 of the most recently written byte |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| array_data | input | 8 | Array contents at the addressed location |
| rd_data | output | 8 | Read data presented to the bus |
| rd_oe | output | 1 | Drive enable for the tri-state data buffers |

## Verification
Reads are framed in four ways: by pulsing output enable only, by pulsing chip enable only, by pulsing both, and by dropping write enable inside a read. These patterns separate a true access edge from a level that merely stays asserted. Each pattern is run with busy high and with busy low, which shows whether the toggle is confined to write cycles. Busy is also dropped in the middle of an access, and a second write cycle checks that the toggle keeps its phase between writes. A long stretch of random strobes with random array and last-written values then compares all eight bits against the bench model on every clock.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;
  localparam int unsigned DATA_W_DEF     = 8;
  localparam int unsigned POLL_BIT_DEF   = 7;
  localparam int unsigned TOGGLE_BIT_DEF = 6;

  typedef enum logic [1:0] {
    LANE_PASS   = 2'd0,
    LANE_POLL   = 2'd1,
    LANE_TOGGLE = 2'd2
  } lane_kind_e;

  function automatic lane_kind_e lane_kind(int unsigned idx, int unsigned poll_b,
                                           int unsigned tog_b);
    if (idx == poll_b) return LANE_POLL;
    if (idx == tog_b) return LANE_TOGGLE;
    return LANE_PASS;
  endfunction
endpackage

// File: rtl/wr_access_detect.sv
module wr_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_act,
  output logic rd_start
);
  logic act_d;

  assign rd_act   = ~ce_n & ~oe_n & we_n;
  assign rd_start = rd_act & ~act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_d <= 1'b0;
    else        act_d <= rd_act;
  end

  p_start_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);
endmodule

// File: rtl/wr_toggle_gen.sv
module wr_toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic tog_next,
  output logic tog_q
);
  assign tog_next = flip ? ~tog_q : tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_next;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flip |=> $stable(tog_q));
  p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/wr_status_mux.sv
module wr_status_mux #(
  parameter int unsigned DATA_W     = wr_status_pkg::DATA_W_DEF,
  parameter int unsigned POLL_BIT   = wr_status_pkg::POLL_BIT_DEF,
  parameter int unsigned TOGGLE_BIT = wr_status_pkg::TOGGLE_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic              busy,
  input  logic              last_wr_bit,
  input  logic              tog_val,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  import wr_status_pkg::*;

  logic [DATA_W-1:0] busy_view;
  logic [DATA_W-1:0] next_data;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    localparam lane_kind_e KIND = lane_kind(i, POLL_BIT, TOGGLE_BIT);
    if (KIND == LANE_POLL) begin : g_poll
      assign busy_view[i] = ~last_wr_bit;
    end else if (KIND == LANE_TOGGLE) begin : g_tog
      assign busy_view[i] = tog_val;
    end else begin : g_pass
      assign busy_view[i] = array_data[i];
    end
  end

  always_comb begin
    if (!rd_act)   next_data = '0;
    else if (busy) next_data = busy_view;
    else           next_data = array_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_oe   <= 1'b0;
    end else begin
      rd_data <= next_data;
      rd_oe   <= rd_act;
    end
  end

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));
  p_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) && $past(busy) |-> rd_data[POLL_BIT] == ~$past(last_wr_bit));
endmodule

// File: rtl/wr_status_reporter.sv
module wr_status_reporter #(
  parameter int unsigned DATA_W     = wr_status_pkg::DATA_W_DEF,
  parameter int unsigned POLL_BIT   = wr_status_pkg::POLL_BIT_DEF,
  parameter int unsigned TOGGLE_BIT = wr_status_pkg::TOGGLE_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              last_wr_bit,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  logic rd_act, rd_start, tog_next, tog_q;

  wr_access_detect u_acc (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_act(rd_act), .rd_start(rd_start)
  );

  wr_toggle_gen u_tog (
    .clk(clk), .rst_n(rst_n), .flip(rd_start & busy),
    .tog_next(tog_next), .tog_q(tog_q)
  );

  wr_status_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .busy(busy),
    .last_wr_bit(last_wr_bit), .tog_val(tog_next), .array_data(array_data),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  p_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> $past(!ce_n && !oe_n && we_n));
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) && !$past(busy) |-> rd_data == $past(array_data));
endmodule

// File: tb/wr_status_reporter_tb.sv
module wr_status_reporter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, last_wr_bit = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] array_data = 8'h00;
  logic [7:0] rd_data;
  logic rd_oe;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wr_status_reporter u_dut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .last_wr_bit(last_wr_bit),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .array_data(array_data),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  // behavioural reference, evaluated at each rising edge
  bit m_prev = 0, m_tog = 0, e_oe = 0;
  bit [7:0] e_data = 0;
  bit e_busy = 0;
  always @(posedge clk) begin
    bit act;
    if (!rst_n) begin
      m_prev = 0; m_tog = 0; e_oe = 0; e_data = 0; e_busy = 0;
    end else begin
      act = !ce_n && !oe_n && we_n;
      if (act && !m_prev && busy) m_tog = !m_tog;
      e_oe = act;
      e_busy = busy;
      if (!act) e_data = 0;
      else if (!busy) e_data = array_data;
      else e_data = {!last_wr_bit, m_tog, array_data[5:0]};
      m_prev = act;
    end
  end

  task automatic check_now();
    total++;
    if (rd_oe !== e_oe) begin
      bad++; $display("FAIL R1 rd_oe act=%b exp=%b", rd_oe, e_oe);
    end else if (!e_oe && rd_data !== 8'h00) begin
      bad++; $display("FAIL R1/R8 idle data act=%h exp=00", rd_data);
    end else if (e_oe && !e_busy && rd_data !== e_data) begin
      bad++; $display("FAIL R2 data act=%h exp=%h", rd_data, e_data);
    end else if (e_oe && e_busy && rd_data[7] !== e_data[7]) begin
      bad++; $display("FAIL R3 bit7 act=%b exp=%b", rd_data[7], e_data[7]);
    end else if (e_oe && e_busy && rd_data[6] !== e_data[6]) begin
      bad++; $display("FAIL R4/R6/R7 bit6 act=%b exp=%b", rd_data[6], e_data[6]);
    end else if (e_oe && e_busy && rd_data[5:0] !== e_data[5:0]) begin
      bad++; $display("FAIL R5 low bits act=%h exp=%h", rd_data[5:0], e_data[5:0]);
    end
  endtask

  always @(negedge clk) check_now();

  task automatic cyc(input bit c, input bit o, input bit w, input bit b, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      ce_n = c; oe_n = o; we_n = w; busy = b;
      array_data = 8'($urandom);
      last_wr_bit = 1'($urandom);
    end
  endtask

  initial begin
    // R8: reset state observed by negedge checks
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2: plain reads while idle
    cyc(0, 0, 1, 0, 4); cyc(1, 1, 1, 0, 2); cyc(0, 0, 1, 0, 3);
    // R7: idle reads leave toggle at 0; then busy with oe pulses (R4, R6)
    for (int k = 0; k < 4; k++) begin cyc(0, 0, 1, 1, 3); cyc(0, 1, 1, 1, 1); end
    // R6: ce pulses only
    for (int k = 0; k < 3; k++) begin cyc(0, 0, 1, 1, 2); cyc(1, 0, 1, 1, 2); end
    // R6: both pulsed
    for (int k = 0; k < 3; k++) begin cyc(0, 0, 1, 1, 1); cyc(1, 1, 1, 1, 1); end
    // R6: we low interrupts the read condition
    cyc(0, 0, 0, 1, 2); cyc(0, 0, 1, 1, 2);
    // R3/R5 busy drops mid-access, then idle reads with gaps (R7)
    cyc(0, 0, 1, 0, 2);
    for (int k = 0; k < 3; k++) begin cyc(0, 0, 1, 0, 2); cyc(1, 1, 1, 0, 1); end
    // R7: second write cycle keeps toggle phase
    for (int k = 0; k < 3; k++) begin cyc(0, 0, 1, 1, 2); cyc(0, 1, 1, 1, 1); end
    // random mix
    for (int k = 0; k < 600; k++)
      cyc(1'($urandom % 3 == 0), 1'($urandom % 3 == 0), 1'($urandom % 5 != 0),
          1'($urandom % 4 != 0), 1);
    cyc(1, 1, 1, 0, 2);
    @(negedge clk); #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule